// File: doc/BRIEF.md
# Serial audio receive-side pin function multiplexer

This block decides what each of two multi-role pads of a receive-side serial audio port carries. The two pads are the receiver frame-sync pad and the receiver high-frequency clock pad. Configuration bits select a role for each pad, and that role sets the pad's output enable and output value, and says which internal signal sees its input level. The roles are:

- a frame sync, in or out;
- a serial flag, in or out;
- a transmit external-buffer enable;
- a high-frequency clock, in or out;
- a general-purpose port bit;
- disconnected.

The output-flag bit is copied to the pad only at a boundary strobe, and the input flag is sampled only at a boundary strobe. The strobe is the frame strobe in normal mode and the slot strobe in network mode. The serial engine, the slot counter, the clock dividers and the register bus are outside this block. Frame and slot boundaries arrive as one-cycle strobes.

The decoded role of each pad is held in a register. A configuration change therefore reaches the pads one clock later. During reset every pad is a disconnected port bit.

Top module: `sai_rx_pin_mux`

## Requirements
- R1: While reset is asserted, every pad output enable is 0. The port-bit inputs, `ext_fs_o`, `ext_hck_o` and `in_flag_o` read 0, whatever the configuration inputs and pad levels are.
- R2: With `ser_en_i`=0, each pad is a port bit configured on its own. `gpio_con_i`=0 gives no drive and a port-bit input of 0. `gpio_con_i`=1 with `gpio_dir_i`=1 drives `gpio_out_i` with the enable at 1. `gpio_con_i`=1 with `gpio_dir_i`=0 leaves the enable at 0. Whenever the pad is connected, the port-bit input shows the pad level. Bit 0 is the frame-sync pad and bit 1 is the clock pad.
- R3: With `ser_en_i`=1 and `sync_mode_i`=0, the frame-sync pad carries the frame sync. With `fs_dir_i`=1 it drives `int_fs_i`. With `fs_dir_i`=0 it is undriven and its level appears on `ext_fs_o`.
- R4: With `ser_en_i`=1, `sync_mode_i`=1 and `bufen_mode_i`=0, the frame-sync pad is a serial flag. With `fs_dir_i`=1 it drives the latched output flag. With `fs_dir_i`=0 it is undriven and acts as the input flag.
- R5: The latched output flag takes `out_flag_i` only on a boundary strobe and holds between strobes. A boundary strobe is `frame_strb_i` when `network_i`=0 and `slot_strb_i` when `network_i`=1.
- R6: `in_flag_o` samples the frame-sync pad level only on a boundary strobe, as defined in R5, while the pad is in the input-flag role. It holds at all other times.
- R7: With `ser_en_i`=1, `sync_mode_i`=1, `bufen_mode_i`=1 and `fs_dir_i`=1, the frame-sync pad drives `tx_shift_i` with the enable at 1. The buffer enable is active high.
- R8: With `ser_en_i`=1, `sync_mode_i`=1, `bufen_mode_i`=1 and `fs_dir_i`=0, the frame-sync pad is undriven. Its level has no effect on `ext_fs_o` or `in_flag_o`.
- R9: With `ser_en_i`=1, the clock pad drives `int_hck_i` when `hck_dir_i`=1. When `hck_dir_i`=0 it is undriven and its level appears on `ext_hck_o`.
- R10: A configuration change shows at the pads on the first rising clock edge after it. Before that edge the previous role still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_en_i | input | 1 | 1: pads carry serial functions; 0: port-bit mode |
| sync_mode_i | input | 1 | Synchronous-mode bit |
| bufen_mode_i | input | 1 | Selects the buffer-enable role in synchronous mode |
| fs_dir_i | input | 1 | Frame-sync pad direction, 1 = output |
| hck_dir_i | input | 1 | Clock pad direction, 1 = output |
| gpio_con_i | input | 2 | Per-pad port-bit connect |
| gpio_dir_i | input | 2 | Per-pad port-bit direction, 1 = output |
| gpio_out_i | input | 2 | Per-pad port-bit output value |
| gpio_in_o | output | 2 | Per-pad port-bit input value |
| network_i | input | 1 | 1: flags follow slot strobes; 0: flags follow frame strobes |
| frame_strb_i | input | 1 | One-cycle frame boundary strobe |
| slot_strb_i | input | 1 | One-cycle slot boundary strobe |
| out_flag_i | input | 1 | Output-flag control bit |
| in_flag_o | output | 1 | Captured input flag |
| int_fs_i | input | 1 | Internally generated frame sync |
| ext_fs_o | output | 1 | Frame sync received from the pad |
| tx_shift_i | input | 1 | Transmitter is shifting out a slot |
| int_hck_i | input | 1 | Internal high-frequency clock to drive out |
| ext_hck_o | output | 1 | Alternate clock received from the pad |
| pad_in_i | input | 2 | Pad levels (bit 0 frame sync, bit 1 clock) |
| pad_out_o | output | 2 | Pad output values |
| pad_oe_o | output | 2 | Pad output enables |

## Verification
The situation hardest to reach from the ports is the frame-sync pad in a flag role, with the strobe of the non-selected boundary kind arriving while the flag source or the pad level differs from the latched value. To reach it, the bench first sweeps all 512 configurations against all 128 data patterns. During that sweep no strobe is given, `out_flag_i` is held at 1 and the latched flag stays 0, so the flag-out pad must show 0 throughout. A directed sequence then fires frame and slot strobes in both normal and network mode, in both flag directions and in the buffer-enable role. After each strobe the pad and `in_flag_o` are compared with the expected held or updated value.

// File: rtl/sai_pin_pkg.sv
package sai_pin_pkg;
  localparam int NUM_PINS = 2;
  localparam int PIN_FS   = 0;
  localparam int PIN_HCK  = 1;

  typedef enum logic [2:0] {
    ROLE_OFF,
    ROLE_GPIO_IN,
    ROLE_GPIO_OUT,
    ROLE_SIG_IN,
    ROLE_SIG_OUT,
    ROLE_FLAG_IN,
    ROLE_FLAG_OUT,
    ROLE_BUFEN
  } pin_role_e;
endpackage

// File: rtl/sai_pin_role_dec.sv
module sai_pin_role_dec
  import sai_pin_pkg::*;
#(
  parameter bit MULTI_ROLE = 1'b0
) (
  input  logic      ser_en_i,
  input  logic      sync_i,
  input  logic      bufen_mode_i,
  input  logic      ser_dir_i,
  input  logic      gpio_con_i,
  input  logic      gpio_dir_i,
  output pin_role_e role_o
);
  pin_role_e ser_role;

  generate
    if (MULTI_ROLE) begin : g_multi
      always_comb begin
        if (!sync_i)            ser_role = ser_dir_i ? ROLE_SIG_OUT  : ROLE_SIG_IN;
        else if (!bufen_mode_i) ser_role = ser_dir_i ? ROLE_FLAG_OUT : ROLE_FLAG_IN;
        else                    ser_role = ser_dir_i ? ROLE_BUFEN    : ROLE_OFF;
      end
    end else begin : g_single
      logic unused_mode;
      assign unused_mode = sync_i ^ bufen_mode_i;
      assign ser_role = ser_dir_i ? ROLE_SIG_OUT : ROLE_SIG_IN;
    end
  endgenerate

  always_comb begin
    if (ser_en_i)        role_o = ser_role;
    else if (!gpio_con_i) role_o = ROLE_OFF;
    else                 role_o = gpio_dir_i ? ROLE_GPIO_OUT : ROLE_GPIO_IN;
  end
endmodule

// File: rtl/sai_pin_drive.sv
module sai_pin_drive
  import sai_pin_pkg::*;
(
  input  pin_role_e role_i,
  input  logic      pad_in_i,
  input  logic      sig_out_i,
  input  logic      flag_out_i,
  input  logic      bufen_i,
  input  logic      gpio_out_i,
  output logic      pad_out_o,
  output logic      pad_oe_o,
  output logic      sig_in_o,
  output logic      flag_sense_o,
  output logic      gpio_in_o
);
  always_comb begin
    pad_out_o    = 1'b0;
    pad_oe_o     = 1'b0;
    sig_in_o     = 1'b0;
    flag_sense_o = 1'b0;
    gpio_in_o    = 1'b0;
    unique case (role_i)
      ROLE_GPIO_IN:  gpio_in_o = pad_in_i;
      ROLE_GPIO_OUT: begin
        pad_oe_o  = 1'b1;
        pad_out_o = gpio_out_i;
        gpio_in_o = pad_in_i;
      end
      ROLE_SIG_IN:   sig_in_o = pad_in_i;
      ROLE_SIG_OUT:  begin
        pad_oe_o  = 1'b1;
        pad_out_o = sig_out_i;
      end
      ROLE_FLAG_IN:  flag_sense_o = 1'b1;
      ROLE_FLAG_OUT: begin
        pad_oe_o  = 1'b1;
        pad_out_o = flag_out_i;
      end
      ROLE_BUFEN:    begin
        pad_oe_o  = 1'b1;
        pad_out_o = bufen_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sai_flag_sync.sv
module sai_flag_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic network_i,
  input  logic frame_strb_i,
  input  logic slot_strb_i,
  input  logic out_flag_i,
  input  logic cap_en_i,
  input  logic cap_val_i,
  output logic of_q_o,
  output logic if_q_o
);
  logic bnd;
  assign bnd = network_i ? slot_strb_i : frame_strb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      of_q_o <= 1'b0;
      if_q_o <= 1'b0;
    end else if (bnd) begin
      of_q_o <= out_flag_i;
      if (cap_en_i) if_q_o <= cap_val_i;
    end
  end
endmodule

// File: rtl/sai_rx_pin_mux.sv
module sai_rx_pin_mux
  import sai_pin_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ser_en_i,
  input  logic                sync_mode_i,
  input  logic                bufen_mode_i,
  input  logic                fs_dir_i,
  input  logic                hck_dir_i,
  input  logic [NUM_PINS-1:0] gpio_con_i,
  input  logic [NUM_PINS-1:0] gpio_dir_i,
  input  logic [NUM_PINS-1:0] gpio_out_i,
  output logic [NUM_PINS-1:0] gpio_in_o,
  input  logic                network_i,
  input  logic                frame_strb_i,
  input  logic                slot_strb_i,
  input  logic                out_flag_i,
  output logic                in_flag_o,
  input  logic                int_fs_i,
  output logic                ext_fs_o,
  input  logic                tx_shift_i,
  input  logic                int_hck_i,
  output logic                ext_hck_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  logic [NUM_PINS-1:0] ser_dir, sig_out, sig_in, flag_sense;
  pin_role_e role_d [NUM_PINS];
  pin_role_e role_q [NUM_PINS];
  logic of_q;

  assign ser_dir[PIN_FS]  = fs_dir_i;
  assign ser_dir[PIN_HCK] = hck_dir_i;
  assign sig_out[PIN_FS]  = int_fs_i;
  assign sig_out[PIN_HCK] = int_hck_i;
  assign ext_fs_o  = sig_in[PIN_FS];
  assign ext_hck_o = sig_in[PIN_HCK];

  logic unused_sense;
  assign unused_sense = flag_sense[PIN_HCK];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    sai_pin_role_dec #(.MULTI_ROLE(p == PIN_FS)) u_dec (
      .ser_en_i     (ser_en_i),
      .sync_i       (sync_mode_i),
      .bufen_mode_i (bufen_mode_i),
      .ser_dir_i    (ser_dir[p]),
      .gpio_con_i   (gpio_con_i[p]),
      .gpio_dir_i   (gpio_dir_i[p]),
      .role_o       (role_d[p])
    );

    // role held in a register so pad drive never glitches on a config write
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) role_q[p] <= ROLE_OFF;
      else         role_q[p] <= role_d[p];
    end

    sai_pin_drive u_drv (
      .role_i       (role_q[p]),
      .pad_in_i     (pad_in_i[p]),
      .sig_out_i    (sig_out[p]),
      .flag_out_i   (of_q),
      .bufen_i      (tx_shift_i),
      .gpio_out_i   (gpio_out_i[p]),
      .pad_out_o    (pad_out_o[p]),
      .pad_oe_o     (pad_oe_o[p]),
      .sig_in_o     (sig_in[p]),
      .flag_sense_o (flag_sense[p]),
      .gpio_in_o    (gpio_in_o[p])
    );
  end

  sai_flag_sync u_flag (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .network_i    (network_i),
    .frame_strb_i (frame_strb_i),
    .slot_strb_i  (slot_strb_i),
    .out_flag_i   (out_flag_i),
    .cap_en_i     (flag_sense[PIN_FS]),
    .cap_val_i    (pad_in_i[PIN_FS]),
    .of_q_o       (of_q),
    .if_q_o       (in_flag_o)
  );
endmodule

// File: rtl/sai_rx_pin_mux_chk.sv
module sai_rx_pin_mux_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ser_en_i,
  input logic       sync_mode_i,
  input logic       bufen_mode_i,
  input logic       fs_dir_i,
  input logic       hck_dir_i,
  input logic [1:0] gpio_con_i,
  input logic [1:0] gpio_in_o,
  input logic       network_i,
  input logic       frame_strb_i,
  input logic       slot_strb_i,
  input logic       in_flag_o,
  input logic       tx_shift_i,
  input logic       int_hck_i,
  input logic [1:0] pad_out_o,
  input logic [1:0] pad_oe_o
);
  logic bnd, fo_cond, be_cond;
  assign bnd     = network_i ? slot_strb_i : frame_strb_i;
  assign fo_cond = ser_en_i && sync_mode_i && !bufen_mode_i && fs_dir_i;
  assign be_cond = ser_en_i && sync_mode_i && bufen_mode_i && fs_dir_i;

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (pad_oe_o == 2'b00 && gpio_in_o == 2'b00 && !in_flag_o)); // R1

  AST_OFF_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && !ser_en_i && !gpio_con_i[0]) |-> (!pad_oe_o[0] && !gpio_in_o[0])); // R2

  AST_OF1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 2) && $past(fo_cond, 2) && $past(fo_cond) && !$past(bnd))
      |-> $stable(pad_out_o[0])); // R5

  AST_IF1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bnd) |-> $stable(in_flag_o)); // R6

  AST_BUFEN_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && be_cond) |-> (pad_oe_o[0] && pad_out_o[0] == tx_shift_i)); // R7

  AST_HCK_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && ser_en_i && hck_dir_i) |-> (pad_oe_o[1] && pad_out_o[1] == int_hck_i)); // R9
endmodule

bind sai_rx_pin_mux sai_rx_pin_mux_chk u_chk (.*);

// File: tb/sai_rx_pin_mux_test.sv
module sai_rx_pin_mux_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_en = 0, sync_mode = 0, bufen_mode = 0, fs_dir = 0, hck_dir = 0;
  logic [1:0] gpio_con = 0, gpio_dir = 0, gpio_out = 0, gpio_in;
  logic network = 0, frame_strb = 0, slot_strb = 0, out_flag = 0, in_flag;
  logic int_fs = 0, ext_fs, tx_shift = 0, int_hck = 0, ext_hck;
  logic [1:0] pad_in = 0, pad_out, pad_oe;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sai_rx_pin_mux uut (
    .clk_i(clk), .rst_ni(rst_n), .ser_en_i(ser_en), .sync_mode_i(sync_mode),
    .bufen_mode_i(bufen_mode), .fs_dir_i(fs_dir), .hck_dir_i(hck_dir),
    .gpio_con_i(gpio_con), .gpio_dir_i(gpio_dir), .gpio_out_i(gpio_out),
    .gpio_in_o(gpio_in), .network_i(network), .frame_strb_i(frame_strb),
    .slot_strb_i(slot_strb), .out_flag_i(out_flag), .in_flag_o(in_flag),
    .int_fs_i(int_fs), .ext_fs_o(ext_fs), .tx_shift_i(tx_shift),
    .int_hck_i(int_hck), .ext_hck_o(ext_hck), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // cfg: [0]ser_en [1]sync [2]bufen [3]fs_dir [4]hck_dir [6:5]gpio_con [8:7]gpio_dir
  task automatic apply_cfg(input logic [8:0] c);
    ser_en = c[0]; sync_mode = c[1]; bufen_mode = c[2]; fs_dir = c[3];
    hck_dir = c[4]; gpio_con = c[6:5]; gpio_dir = c[8:7];
  endtask

  // data: [1:0]pad_in [2]int_fs [3]tx_shift [4]int_hck [6:5]gpio_out
  task automatic apply_data(input logic [6:0] d);
    pad_in = d[1:0]; int_fs = d[2]; tx_shift = d[3]; int_hck = d[4]; gpio_out = d[6:5];
  endtask

  task automatic set_cfg(input logic [8:0] c);
    @(negedge clk); apply_cfg(c); @(negedge clk);
  endtask

  task automatic strobe(input logic f, input logic s);
    @(negedge clk); frame_strb = f; slot_strb = s;
    @(negedge clk); frame_strb = 0; slot_strb = 0;
  endtask

  // {oe, out, ext, gpio_in} for the frame-sync pad
  function automatic logic [3:0] exp_fs(input logic [8:0] c, input logic [6:0] d, input logic of1);
    logic oe = 0, o = 0, e = 0, g = 0;
    if (!c[0]) begin
      if (c[5]) begin g = d[0]; if (c[7]) begin oe = 1; o = d[5]; end end
    end else if (!c[1]) begin
      if (c[3]) begin oe = 1; o = d[2]; end else e = d[0];
    end else if (!c[2]) begin
      if (c[3]) begin oe = 1; o = of1; end
    end else if (c[3]) begin
      oe = 1; o = d[3];
    end
    return {oe, o, e, g};
  endfunction

  function automatic logic [3:0] exp_hck(input logic [8:0] c, input logic [6:0] d);
    logic oe = 0, o = 0, e = 0, g = 0;
    if (!c[0]) begin
      if (c[6]) begin g = d[1]; if (c[8]) begin oe = 1; o = d[6]; end end
    end else if (c[4]) begin
      oe = 1; o = d[4];
    end else e = d[1];
    return {oe, o, e, g};
  endfunction

  function automatic string fs_tag(input logic [8:0] c);
    if (!c[0]) return "R2";
    if (!c[1]) return "R3";
    if (!c[2]) return "R4/R5";
    return c[3] ? "R7" : "R8";
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R1: reset with every input active
    apply_cfg(9'h1FF); apply_data(7'h7F); out_flag = 1;
    #(CLK_PERIOD * 3);
    chk("R1 oe", {2'b00, pad_oe}, 4'b0000);
    chk("R1 gpio_in/flag", {1'b0, gpio_in, in_flag}, 4'b0000);
    chk("R1 ext", {2'b00, ext_fs, ext_hck}, 4'b0000);
    @(negedge clk); apply_cfg(9'h000); apply_data(7'h00);
    @(negedge clk); rst_n = 1;

    // R2 R3 R4 R7 R8 R9: all configs x all data; out_flag=1 but no strobe, so latched flag stays 0 (R5)
    for (int c = 0; c < 512; c++) begin
      @(negedge clk); apply_cfg(9'(c));
      @(posedge clk);
      for (int d = 0; d < 128; d++) begin
        apply_data(7'(d)); #1;
        chk(fs_tag(9'(c)), {pad_oe[0], pad_out[0], ext_fs, gpio_in[0]}, exp_fs(9'(c), 7'(d), 1'b0));
        chk(c[0] ? "R9" : "R2", {pad_oe[1], pad_out[1], ext_hck, gpio_in[1]}, exp_hck(9'(c), 7'(d)));
        chk("R6 no strobe", {3'b000, in_flag}, 4'b0000);
      end
    end

    // R5: output flag
    apply_data(7'h00); network = 0; out_flag = 1;
    set_cfg(9'h00B);
    chk("R5 held before strobe", {2'b00, pad_oe[0], pad_out[0]}, 4'b0010);
    strobe(0, 1);
    chk("R5 slot strobe ignored in normal mode", {3'b000, pad_out[0]}, 4'b0000);
    strobe(1, 0);
    chk("R5 frame strobe updates", {3'b000, pad_out[0]}, 4'b0001);
    out_flag = 0;
    @(negedge clk); @(negedge clk);
    chk("R5 write between boundaries held", {3'b000, pad_out[0]}, 4'b0001);
    network = 1;
    strobe(1, 0);
    chk("R5 frame strobe ignored in network mode", {3'b000, pad_out[0]}, 4'b0001);
    strobe(0, 1);
    chk("R5 slot strobe updates", {3'b000, pad_out[0]}, 4'b0000);

    // R6: input flag
    network = 0; set_cfg(9'h003); pad_in = 2'b01;
    @(negedge clk);
    chk("R4 input flag undriven", {2'b00, pad_oe[0], in_flag}, 4'b0000);
    strobe(1, 0);
    chk("R6 frame strobe captures", {3'b000, in_flag}, 4'b0001);
    pad_in = 2'b00;
    strobe(0, 1);
    chk("R6 slot strobe ignored in normal mode", {3'b000, in_flag}, 4'b0001);
    network = 1;
    strobe(0, 1);
    chk("R6 slot strobe captures", {3'b000, in_flag}, 4'b0000);
    pad_in = 2'b01;
    strobe(1, 0);
    chk("R6 frame strobe ignored in network mode", {3'b000, in_flag}, 4'b0000);
    strobe(0, 1);
    chk("R6 slot strobe captures high", {3'b000, in_flag}, 4'b0001);

    // R8: buffer-enable mode with input direction ignores the pad
    set_cfg(9'h007); pad_in = 2'b00;
    strobe(0, 1);
    chk("R8 flag not captured", {3'b000, in_flag}, 4'b0001);
    pad_in = 2'b01; #1;
    chk("R8 pad undriven, ext_fs 0", {2'b00, pad_oe[0], ext_fs}, 4'b0000);

    // R7: buffer enable follows transmitter
    set_cfg(9'h00F); tx_shift = 1; #1;
    chk("R7 bufen high", {2'b00, pad_oe[0], pad_out[0]}, 4'b0011);
    tx_shift = 0; #1;
    chk("R7 bufen low", {2'b00, pad_oe[0], pad_out[0]}, 4'b0010);

    // R10: one-clock latency
    @(negedge clk); apply_cfg(9'h000); #1;
    chk("R10 old role before edge", {3'b000, pad_oe[0]}, 4'b0001);
    @(posedge clk); #1;
    chk("R10 new role after edge", {3'b000, pad_oe[0]}, 4'b0000);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule